// File: doc/BRIEF.md
# Oversampled Sample Trigger Generator

This block issues ADC sample requests inside each switching period of a PWM. It watches a free-running period counter and a period-start strobe. Each period it fires one, two, four or eight single-cycle sample pulses. The pulses are spread evenly over the interval that runs from the start of the period to a programmed trigger position. The last pulse always lands exactly on that trigger position.

Each pulse comes with a 3-bit sample index, so averaging logic further down the line can tag each conversion result. The trigger position and the oversampling select are latched only on the period-start strobe. A register write made in the middle of a period therefore takes effect in the following period. The block latches the full set of thresholds when it captures the settings, and then compares the counter against them one cycle at a time.

Top module: `ostg_sample_trig`

## Requirements
- R1: While rst_ni is low, and until the first strobe, sample_o is 0 and sample_idx_o is 0.
- R2: The oversampling select os_sel_i encodes 0, 1, 2 and 3 as N = 1, 2, 4 and 8 samples per period. When the trigger value T is at least N, exactly N pulses are issued in the period, with indices 0 to N-1.
- R3: Pulse k (k = 0 to N-2) is raised when the counter equals floor((k+1)*T/N). sample_o goes high in the cycle after cnt_i holds that value, and sample_idx_o = k in that same cycle.
- R4: Pulse N-1 is raised when the counter equals T exactly, whatever the rounding of the other pulses.
- R5: trig_pos_i and os_sel_i are sampled only in a cycle where period_start_i is high. Changes to them at any other time do not affect the pulses of the current period.
- R6: Each pulse lasts one clock. When sample_o is low, sample_idx_o is 0.
- R7: When several thresholds are equal, they produce a single pulse that carries the highest matching index. No period ever sees more than N pulses.
- R8: A threshold of zero is never issued. A trigger value of 0 therefore gives no pulses in that period.
- R9: The cycle after a strobe cycle never carries a pulse, even if cnt_i matched a threshold during the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_start_i | input | 1 | Period-start strobe; latches the configuration |
| cnt_i | input | CW | Free-running period counter |
| trig_pos_i | input | CW | Trigger position in counter ticks |
| os_sel_i | input | 2 | Oversampling select (0..3 gives 1, 2, 4 or 8 samples) |
| sample_o | output | 1 | Single-cycle sample request |
| sample_idx_o | output | 3 | Index of the current sample within the period |

## Verification
Every pulse is due exactly one cycle after the counter value that matches it. That cycle holds one compare stage plus the output register. A configuration latched on a strobe governs the compares from the next cycle onward. The bench drives each input set on a falling edge and predicts the output from a latched model of the configuration. It then checks that prediction on the next falling edge, which is one cycle later. Pulse counts per period are checked after one extra trailing cycle, so that the last pulse has arrived before the count is compared.

// File: rtl/ostg_pkg.sv
package ostg_pkg;
  localparam int unsigned LANES = 8;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [1:0] {
    OS_X1 = 2'd0,
    OS_X2 = 2'd1,
    OS_X4 = 2'd2,
    OS_X8 = 2'd3
  } os_sel_e;

  function automatic logic [IDX_W:0] lane_count(input logic [1:0] sel);
    return (IDX_W+1)'(1) << sel;
  endfunction
endpackage

// File: rtl/ostg_thresh.sv
module ostg_thresh
  import ostg_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0]             trig_i,
  input  logic [1:0]                sel_i,
  output logic [LANES-1:0][CW-1:0] thr_o,
  output logic [LANES-1:0]         en_o
);
  localparam int unsigned PW = CW + IDX_W;

  logic [IDX_W:0] n_lanes;
  assign n_lanes = lane_count(sel_i);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PW-1:0] prod;
    logic [PW-1:0] frac;
    assign prod = PW'(k + 1) * PW'(trig_i);
    assign frac = prod >> sel_i;
    // final lane pinned to the exact trigger value
    assign thr_o[k] = ((IDX_W+1)'(k + 1) == n_lanes) ? trig_i : frac[CW-1:0];
    assign en_o[k]  = ((IDX_W+1)'(k) < n_lanes);
  end
endmodule

// File: rtl/ostg_match.sv
module ostg_match
  import ostg_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0]             cnt_i,
  input  logic [LANES-1:0][CW-1:0] thr_i,
  input  logic [LANES-1:0]         en_i,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [LANES-1:0] eq;

  for (genvar k = 0; k < LANES; k++) begin : g_cmp
    assign eq[k] = en_i[k] && (thr_i[k] != '0) && (cnt_i == thr_i[k]);
  end

  // highest matching lane wins
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (eq[k]) idx_o = IDX_W'(k);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/ostg_sample_trig.sv
module ostg_sample_trig
  import ostg_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_start_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [CW-1:0]    trig_pos_i,
  input  logic [1:0]       os_sel_i,
  output logic             sample_o,
  output logic [IDX_W-1:0] sample_idx_o
);
  logic [LANES-1:0][CW-1:0] thr_d, thr_q;
  logic [LANES-1:0]         en_d, en_q;
  logic [CW-1:0]            trig_q;
  logic [1:0]               sel_q;
  logic                     hit;
  logic [IDX_W-1:0]         hit_idx;

  ostg_thresh #(.CW(CW)) u_thresh (
    .trig_i (trig_pos_i),
    .sel_i  (os_sel_i),
    .thr_o  (thr_d),
    .en_o   (en_d)
  );

  ostg_match #(.CW(CW)) u_match (
    .cnt_i  (cnt_i),
    .thr_i  (thr_q),
    .en_i   (en_q),
    .hit_o  (hit),
    .idx_o  (hit_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      en_q   <= '0;
      trig_q <= '0;
      sel_q  <= 2'(OS_X1);
    end else if (period_start_i) begin
      thr_q  <= thr_d;
      en_q   <= en_d;
      trig_q <= trig_pos_i;
      sel_q  <= os_sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o     <= 1'b0;
      sample_idx_o <= '0;
    end else begin
      sample_o     <= hit && !period_start_i;
      sample_idx_o <= (hit && !period_start_i) ? hit_idx : '0;
    end
  end
endmodule

// File: rtl/ostg_sample_trig_chk.sv
module ostg_sample_trig_chk
  import ostg_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             period_start_i,
  input logic [CW-1:0]    cnt_i,
  input logic             sample_o,
  input logic [IDX_W-1:0] sample_idx_o,
  input logic [CW-1:0]    trig_q,
  input logic [1:0]       sel_q
);
  logic [IDX_W:0] npulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             npulse <= '0;
    else if (period_start_i) npulse <= '0;
    else if (sample_o)       npulse <= npulse + 1'b1;
  end

  assert_idx_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> ({1'b0, sample_idx_o} < lane_count(sel_q)));

  assert_last_on_trig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && ({1'b0, sample_idx_o} == lane_count(sel_q) - 1'b1)) |-> ($past(cnt_i) == trig_q));

  assert_idle_idx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_o |-> (sample_idx_o == '0));

  assert_max_pulses_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    npulse <= lane_count(sel_q));

  assert_zero_trig_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((trig_q == '0) && !period_start_i) |=> !sample_o);

  assert_strobe_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_i |=> !sample_o);
endmodule

bind ostg_sample_trig ostg_sample_trig_chk #(.CW(CW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .period_start_i (period_start_i),
  .cnt_i          (cnt_i),
  .sample_o       (sample_o),
  .sample_idx_o   (sample_idx_o),
  .trig_q         (trig_q),
  .sel_q          (sel_q)
);

// File: tb/ostg_sample_trig_bench.sv
`timescale 1ns/1ps
module ostg_sample_trig_bench;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          period_start_i = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic [CW-1:0] trig_pos_i = '0;
  logic [1:0]    os_sel_i = '0;
  logic          sample_o;
  logic [2:0]    sample_idx_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  int m_trig = 0, m_sel = 0;
  bit exp_s = 0;
  int exp_i = 0;
  int seen = 0;

  always #2.5 clk_i = ~clk_i;

  ostg_sample_trig #(.CW(CW)) u_ostg_sample_trig (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_start_i(period_start_i),
    .cnt_i(cnt_i), .trig_pos_i(trig_pos_i), .os_sel_i(os_sel_i),
    .sample_o(sample_o), .sample_idx_o(sample_idx_o)
  );

  function automatic int thr(input int t, input int sel, input int k);
    int n = 1 << sel;
    return (k == n - 1) ? t : ((k + 1) * t) / n;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step(input bit st, input int c, input int t, input int sel);
    @(negedge clk_i);
    check(exp_s ? "R3/R4" : "R6/R9", {31'd0, sample_o}, {31'd0, exp_s});
    check(exp_s ? "R3 index" : "R6 idle index", {29'd0, sample_idx_o}, exp_i);
    if (sample_o) seen++;
    period_start_i = st;
    cnt_i = CW'(c);
    trig_pos_i = CW'(t);
    os_sel_i = 2'(sel);
    exp_s = 0;
    exp_i = 0;
    if (st) begin
      m_trig = t;
      m_sel = sel;
    end else begin
      for (int k = 0; k < (1 << m_sel); k++) begin
        int h = thr(m_trig, m_sel, k);
        if (h != 0 && h == c) begin
          exp_s = 1;
          exp_i = k;  // R7: highest index of a collapsed group
        end
      end
    end
  endtask

  task automatic run_period(input int t, input int sel, input bit noise);
    int n = 1 << sel;
    int want = 0;
    for (int k = 0; k < n; k++) begin
      int h = thr(t, sel, k);
      if (h != 0 && (k == 0 || h != thr(t, sel, k - 1))) want++;
    end
    step(1, 0, t, sel);
    seen = 0;
    for (int c = 1; c <= t + 2; c++) begin
      // R5: disturb configuration mid-period
      if (noise) step(0, c, t ^ 16'h00a5, 3 - sel);
      else       step(0, c, t, sel);
    end
    check("R2/R7/R8 pulse count", seen, want);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 sample in reset", {31'd0, sample_o}, 0);
    check("R1 index in reset", {29'd0, sample_idx_o}, 0);
    rst_ni = 1'b1;
    // R1: no pulses before the first strobe
    for (int c = 0; c < 6; c++) step(0, c, 3, 0);
    for (int sel = 0; sel < 4; sel++)
      for (int t = 0; t <= 40; t++)
        run_period(t, sel, t[0]);
    // R3 R4: larger trigger values with uneven rounding
    run_period(1023, 3, 1);
    run_period(1001, 2, 0);
    run_period(999, 1, 1);
    // R9: strobe in the cycle the counter matches the old trigger
    step(1, 0, 10, 0);
    for (int c = 1; c < 10; c++) step(0, c, 10, 0);
    step(1, 10, 12, 0);
    step(0, 11, 12, 0);
    step(0, 12, 12, 0);
    step(0, 13, 12, 0);
    step(0, 14, 12, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule